// File: doc/BRIEF.md
# Wishbone Burst RAM Slave

This block is a single-port on-chip memory with a Wishbone slave port. It serves classic single-word reads and writes. It also serves registered-feedback bursts, where the master announces with its cycle-type and burst-type signals what the next address will be. The slave computes that next address itself while the current beat is being acknowledged. Once the first wait state has passed, it can therefore return one beat on every clock.

The address input is a word address; the byte address on the bus side is two bits wider. On a write, the byte-select lines choose which 8-bit lanes of the word change. Two parameters switch features off. One makes every access a classic single-beat transfer. The other makes every write update the whole word whatever the select lines say. The error and retry outputs are always inactive.

Top module: `wb_burst_ram`

## Requirements
- R1: A classic access (cycle type 000, or any beat with no burst pending) raises acknowledge in the clock after strobe and cycle are both seen high with no acknowledge pending. Acknowledge stays high for that one clock and then stays low for at least one clock. On a read, the addressed word is on the data output while acknowledge is high.
- R2: On a write with byte enables active, select bit i lets data bits 8i+7..8i reach the addressed word, and the other lanes keep their contents. A write with all select bits low changes nothing.
- R3: With byte enables switched off by parameter, every write stores the full data word whatever the select lines carry.
- R4: A burst announced with cycle type 010 and burst type 00 (linear) is acknowledged on every clock. The word address rises by one per beat. Acknowledge falls in the clock after the beat that carries cycle type 111.
- R5: Burst types 01, 10 and 11 are wrapping bursts of 4, 8 and 16 beats. Only the low 2, 3 or 4 word-address bits step, modulo the wrap length, and the upper bits keep the start value.
- R6: Each acknowledged write beat of a burst stores its data at that beat's address, in the same address order as a read burst.
- R7: If strobe falls while a burst beat is pending with cycle still high, acknowledge is withheld. The prepared address and the read data are kept, and the same beat completes once strobe returns.
- R8: The error and retry outputs are always low.
- R9: With bursts switched off by parameter, a held strobe with cycle type 010 is still served as classic accesses. Acknowledge alternates high and low, with one wait state per beat.
- R10: While reset is high, acknowledge stays low even with strobe and cycle high. After reset, the data output is zero.
- R11: Dropping cycle while a beat is pending cancels it. The next request then waits one clock for its acknowledge again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| datIn | input | DW | Write data |
| selIn | input | DW/8 | Byte-lane select |
| addrIn | input | AW | Word address |
| ctiIn | input | 3 | Cycle type: 000 classic, 010 incrementing burst, 111 last beat |
| bteIn | input | 2 | Burst type: 00 linear, 01 wrap-4, 10 wrap-8, 11 wrap-16 |
| stbIn | input | 1 | Strobe |
| cycIn | input | 1 | Bus cycle valid |
| weIn | input | 1 | Write enable |
| datOut | output | DW | Read data |
| ackOut | output | 1 | Acknowledge |
| errOut | output | 1 | Error, held low |
| rtyOut | output | 1 | Retry, held low |

## Verification
On every clock, the embedded properties check four things. Acknowledge starts and ends as it should for classic, burst and no-burst beats. An abort clears the pending beat. The next address steps by one for linear bursts, or inside the wrap window with the upper bits frozen. Data holds during a strobe stall. Only the bench scenarios can show that the right memory words come back: byte-lane merges, full-word writes with byte enables off, and burst writes that land in wrap order. They also show that a stalled burst resumes on the same beat and that the reset state is visible at the ports.

// File: rtl/bram_pkg.sv
package bram_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // first beat: capture the bus address and read it
    logic advance;   // burst beat completed: step to the next address and read it
    logic commitWr;  // beat completed with write enable: store at the current address
  } ramCtl_t;

  localparam logic [2:0] CYC_CLASSIC = 3'b000;
  localparam logic [2:0] CYC_INCR    = 3'b010;
  localparam logic [2:0] CYC_LAST    = 3'b111;

  localparam logic [1:0] BT_LINEAR = 2'b00;
  localparam logic [1:0] BT_WRAP4  = 2'b01;
  localparam logic [1:0] BT_WRAP8  = 2'b10;
  localparam logic [1:0] BT_WRAP16 = 2'b11;
endpackage

// File: rtl/bram_ctrl.sv
module bram_ctrl
  import bram_pkg::*;
#(
  parameter bit BURST_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stbIn,
  input  logic       cycIn,
  input  logic       weIn,
  input  logic [2:0] ctiIn,
  output logic       ackPend,
  output ramCtl_t    ctl
);
  logic beatDone;
  logic keepGoing;

  assign beatDone = ackPend & stbIn & cycIn;

  generate
    if (BURST_EN) begin : g_burst
      assign keepGoing = (ctiIn == CYC_INCR);
    end else begin : g_single
      assign keepGoing = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl          = '0;
    ctl.loadReq  = !ackPend && stbIn && cycIn;
    ctl.advance  = beatDone && keepGoing;
    ctl.commitWr = beatDone && weIn;
  end

  always_ff @(posedge clk) begin
    if (rst)               ackPend <= 1'b0;
    else if (!cycIn)       ackPend <= 1'b0;
    else if (ctl.loadReq)  ackPend <= 1'b1;
    else if (beatDone)     ackPend <= keepGoing;
  end

  // R1
  req_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!ackPend && stbIn && cycIn) |=> ackPend);

  // R1
  classic_single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (beatDone && ctiIn != CYC_INCR) |=> !ackPend);

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ackPend && !cycIn) |=> !ackPend);

  generate
    if (BURST_EN) begin : g_burstChk
      // R4
      burst_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (beatDone && ctiIn == CYC_INCR) |=> ackPend);
    end else begin : g_singleChk
      // R9
      noburst_single_chk: assert property (@(posedge clk) disable iff (rst)
        beatDone |=> !ackPend);
    end
  endgenerate
endmodule

// File: rtl/bram_dp.sv
module bram_dp
  import bram_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 12,
  parameter bit          BYTE_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ramCtl_t              ctl,
  input  logic [AW-1:0]        addrIn,
  input  logic [1:0]           bteIn,
  input  logic [DW-1:0]        datIn,
  input  logic [DW/8-1:0]      selIn,
  output logic [DW-1:0]        rdData
);
  localparam int unsigned SELW  = DW / 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   curAddr;
  logic [AW-1:0]   nxtAddr;
  logic [AW-1:0]   wrapMask;
  logic [SELW-1:0] laneEn;

  always_comb begin
    case (bteIn)
      BT_WRAP4:  wrapMask = AW'(3);
      BT_WRAP8:  wrapMask = AW'(7);
      BT_WRAP16: wrapMask = AW'(15);
      default:   wrapMask = '1;
    endcase
  end

  assign nxtAddr = (curAddr & ~wrapMask) | ((curAddr + 1'b1) & wrapMask);

  for (genvar g = 0; g < SELW; g++) begin : g_lane
    assign laneEn[g] = selIn[g] | ~BYTE_EN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
      rdData  <= '0;
    end else if (ctl.loadReq) begin
      curAddr <= addrIn;
      rdData  <= mem[addrIn];
    end else if (ctl.advance) begin
      curAddr <= nxtAddr;
      rdData  <= mem[nxtAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.commitWr) begin
      for (int i = 0; i < SELW; i++) begin
        if (laneEn[i]) mem[curAddr][8*i +: 8] <= datIn[8*i +: 8];
      end
    end
  end

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && bteIn == BT_LINEAR) |=> curAddr == $past(curAddr) + 1'b1);

  // R5
  wrap_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && bteIn != BT_LINEAR) |=>
      ((curAddr ^ $past(curAddr)) & ~$past(wrapMask)) == '0);

  // R5
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.advance && bteIn != BT_LINEAR) |=>
      (curAddr & $past(wrapMask)) == (($past(curAddr) + 1'b1) & $past(wrapMask)));
endmodule

// File: rtl/wb_burst_ram.sv
module wb_burst_ram
  import bram_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 12,
  parameter bit          BURST_EN = 1'b1,
  parameter bit          BYTE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     datIn,
  input  logic [DW/8-1:0]   selIn,
  input  logic [AW-1:0]     addrIn,
  input  logic [2:0]        ctiIn,
  input  logic [1:0]        bteIn,
  input  logic              stbIn,
  input  logic              cycIn,
  input  logic              weIn,
  output logic [DW-1:0]     datOut,
  output logic              ackOut,
  output logic              errOut,
  output logic              rtyOut
);
  ramCtl_t ctl;
  logic    ackPend;

  bram_ctrl #(.BURST_EN(BURST_EN)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .stbIn   (stbIn),
    .cycIn   (cycIn),
    .weIn    (weIn),
    .ctiIn   (ctiIn),
    .ackPend (ackPend),
    .ctl     (ctl)
  );

  bram_dp #(.DW(DW), .AW(AW), .BYTE_EN(BYTE_EN)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .addrIn (addrIn),
    .bteIn  (bteIn),
    .datIn  (datIn),
    .selIn  (selIn),
    .rdData (datOut)
  );

  assign ackOut = ackPend & stbIn & cycIn;
  assign errOut = 1'b0;
  assign rtyOut = 1'b0;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ackPend && cycIn && !stbIn) |=> $stable(datOut));
endmodule

// File: tb/wb_burst_ram_tb.sv
module wb_burst_ram_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] datIn = '0;
  logic [3:0]  selIn = 4'hF;
  logic [11:0] addrIn = '0;
  logic [2:0]  ctiIn = 3'b000;
  logic [1:0]  bteIn = 2'b00;
  logic        stb = 1'b0, cyc = 1'b0, we = 1'b0, useP = 1'b0;
  logic        mStb, pStb;
  logic [31:0] mDat, pDat;
  logic        mAck, mErr, mRty, pAck, pErr, pRty;
  int          total = 0, bad = 0;
  logic [31:0] model [4096];

  assign mStb = stb & ~useP;
  assign pStb = stb & useP;

  always #2.5 clk = ~clk;

  wb_burst_ram u_dut (
    .clk(clk), .rst(rst), .datIn(datIn), .selIn(selIn), .addrIn(addrIn),
    .ctiIn(ctiIn), .bteIn(bteIn), .stbIn(mStb), .cycIn(cyc), .weIn(we),
    .datOut(mDat), .ackOut(mAck), .errOut(mErr), .rtyOut(mRty));

  wb_burst_ram #(.BURST_EN(1'b0), .BYTE_EN(1'b0)) u_plain (
    .clk(clk), .rst(rst), .datIn(datIn), .selIn(selIn), .addrIn(addrIn),
    .ctiIn(ctiIn), .bteIn(bteIn), .stbIn(pStb), .cycIn(cyc), .weIn(we),
    .datOut(pDat), .ackOut(pAck), .errOut(pErr), .rtyOut(pRty));

  // {addr, sel, write data, expected read-back}
  localparam logic [79:0] VEC [7] = '{
    {12'h010, 4'hF, 32'h11223344, 32'h11223344},
    {12'h010, 4'h1, 32'hAAAAAAAA, 32'h112233AA},
    {12'h010, 4'h6, 32'hBBCCDDEE, 32'h11CCDDAA},
    {12'h7FF, 4'hF, 32'hCAFEF00D, 32'hCAFEF00D},
    {12'h7FF, 4'h8, 32'h12345678, 32'h12FEF00D},
    {12'hFFF, 4'hF, 32'h0BADBEEF, 32'h0BADBEEF},
    {12'hFFF, 4'h0, 32'hFFFFFFFF, 32'h0BADBEEF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic curAck();
    return useP ? pAck : mAck;
  endfunction

  function automatic logic [31:0] curDat();
    return useP ? pDat : mDat;
  endfunction

  function automatic logic [11:0] nextA(input logic [11:0] a, input logic [1:0] bt);
    case (bt)
      2'b01:   return {a[11:2], a[1:0] + 2'd1};
      2'b10:   return {a[11:3], a[2:0] + 3'd1};
      2'b11:   return {a[11:4], a[3:0] + 4'd1};
      default: return a + 12'd1;
    endcase
  endfunction

  task automatic classicWrite(input logic [11:0] a, input logic [3:0] s, input logic [31:0] d, input string req);
    @(negedge clk);
    addrIn = a; selIn = s; datIn = d; we = 1'b1; ctiIn = 3'b000; bteIn = 2'b00; stb = 1'b1; cyc = 1'b1;
    @(negedge clk);
    check(curAck() == 1'b1, req, {31'b0, curAck()}, 32'd1);
    @(negedge clk);
    check(curAck() == 1'b0, req, {31'b0, curAck()}, 32'd0);
    stb = 1'b0; cyc = 1'b0; we = 1'b0; selIn = 4'hF;
  endtask

  task automatic classicRead(input logic [11:0] a, output logic [31:0] d, input string req);
    @(negedge clk);
    addrIn = a; we = 1'b0; ctiIn = 3'b000; bteIn = 2'b00; stb = 1'b1; cyc = 1'b1;
    @(negedge clk);
    check(curAck() == 1'b1, req, {31'b0, curAck()}, 32'd1);
    d = curDat();
    @(negedge clk);
    check(curAck() == 1'b0, req, {31'b0, curAck()}, 32'd0);
    stb = 1'b0; cyc = 1'b0;
  endtask

  task automatic driveBeat(input logic [11:0] a, input bit last, input bit wr,
                           input logic [1:0] bt, input logic [31:0] seed);
    addrIn = a; ctiIn = last ? 3'b111 : 3'b010; bteIn = bt; we = wr; selIn = 4'hF;
    datIn = seed ^ {20'h0, a}; stb = 1'b1; cyc = 1'b1;
    if (wr) model[a] = seed ^ {20'h0, a};
  endtask

  task automatic burst(input bit wr, input logic [11:0] a0, input logic [1:0] bt,
                       input int n, input logic [31:0] seed, input string req);
    logic [11:0] a;
    a = a0;
    @(negedge clk);
    driveBeat(a, n == 1, wr, bt, seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        a = nextA(a, bt);
        driveBeat(a, k == n - 1, wr, bt, seed);
      end
      check(mAck == 1'b1, req, {31'b0, mAck}, 32'd1);
      if (!wr) check(mDat == model[a], req, mDat, model[a]);
    end
    @(negedge clk);
    check(mAck == 1'b0, req, {31'b0, mAck}, 32'd0);
    stb = 1'b0; cyc = 1'b0; we = 1'b0; ctiIn = 3'b000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    // R10: request held during reset gets no acknowledge
    @(negedge clk);
    stb = 1'b1; cyc = 1'b1;
    repeat (3) @(negedge clk);
    check(mAck == 1'b0, "R10", {31'b0, mAck}, 32'd0);
    stb = 1'b0; cyc = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mDat == 32'h0, "R10", mDat, 32'h0);
    check(mAck == 1'b0, "R10", {31'b0, mAck}, 32'd0);

    // R1 R2: table of classic writes with byte lanes, each read back
    for (int v = 0; v < 7; v++) begin
      classicWrite(VEC[v][79:68], VEC[v][67:64], VEC[v][63:32], "R2");
      model[VEC[v][79:68]] = VEC[v][31:0];
      classicRead(VEC[v][79:68], rd, "R1");
      check(rd == VEC[v][31:0], "R2", rd, VEC[v][31:0]);
    end

    // R6: linear burst write fills 0x100..0x11F
    burst(1'b1, 12'h100, 2'b00, 32, 32'hA5000000, "R6");
    // R4: linear burst read
    burst(1'b0, 12'h103, 2'b00, 5, 32'h0, "R4");
    // R5: wrapping reads of each length
    burst(1'b0, 12'h106, 2'b01, 6, 32'h0, "R5");
    burst(1'b0, 12'h10D, 2'b10, 9, 32'h0, "R5");
    burst(1'b0, 12'h11E, 2'b11, 17, 32'h0, "R5");
    // R6: wrap-4 write lands in wrap order, neighbours untouched
    burst(1'b1, 12'h10A, 2'b01, 4, 32'h3C000000, "R6");
    classicRead(12'h108, rd, "R6");
    check(rd == (32'h3C000000 ^ 32'h108), "R6", rd, 32'h3C000000 ^ 32'h108);
    classicRead(12'h107, rd, "R6");
    check(rd == (32'hA5000000 ^ 32'h107), "R6", rd, 32'hA5000000 ^ 32'h107);
    classicRead(12'h10C, rd, "R6");
    check(rd == (32'hA5000000 ^ 32'h10C), "R6", rd, 32'hA5000000 ^ 32'h10C);

    // R7: strobe stall during beat 1 of a linear burst
    @(negedge clk);
    driveBeat(12'h100, 1'b0, 1'b0, 2'b00, 32'h0);
    @(negedge clk);
    check(mAck == 1'b1 && mDat == model[12'h100], "R7", mDat, model[12'h100]);
    @(negedge clk);
    driveBeat(12'h101, 1'b0, 1'b0, 2'b00, 32'h0);
    check(mAck == 1'b1 && mDat == model[12'h101], "R7", mDat, model[12'h101]);
    stb = 1'b0;
    @(negedge clk);
    check(mAck == 1'b0, "R7", {31'b0, mAck}, 32'd0);
    check(mDat == model[12'h101], "R7", mDat, model[12'h101]);
    @(negedge clk);
    check(mDat == model[12'h101], "R7", mDat, model[12'h101]);
    stb = 1'b1;
    #1;
    check(mAck == 1'b1, "R7", {31'b0, mAck}, 32'd1);
    @(negedge clk);
    driveBeat(12'h102, 1'b1, 1'b0, 2'b00, 32'h0);
    check(mAck == 1'b1 && mDat == model[12'h102], "R7", mDat, model[12'h102]);
    @(negedge clk);
    check(mAck == 1'b0, "R7", {31'b0, mAck}, 32'd0);
    stb = 1'b0; cyc = 1'b0; ctiIn = 3'b000;

    // R11: cycle dropped mid-burst, next request waits again
    @(negedge clk);
    driveBeat(12'h108, 1'b0, 1'b0, 2'b00, 32'h0);
    @(negedge clk);
    check(mAck == 1'b1, "R11", {31'b0, mAck}, 32'd1);
    stb = 1'b0; cyc = 1'b0;
    @(negedge clk);
    addrIn = 12'h109; ctiIn = 3'b000; stb = 1'b1; cyc = 1'b1;
    #1;
    check(mAck == 1'b0, "R11", {31'b0, mAck}, 32'd0);
    @(negedge clk);
    check(mAck == 1'b1 && mDat == model[12'h109], "R11", mDat, model[12'h109]);
    @(negedge clk);
    stb = 1'b0; cyc = 1'b0;

    // R8: error and retry stay low
    check(mErr == 1'b0 && mRty == 1'b0, "R8", {30'b0, mErr, mRty}, 32'd0);

    // R3: byte enables off, single select bit still writes the full word
    useP = 1'b1;
    classicWrite(12'h020, 4'h1, 32'h12345678, "R3");
    classicRead(12'h020, rd, "R3");
    check(rd == 32'h12345678, "R3", rd, 32'h12345678);

    // R9: bursts off, a held incrementing request alternates acknowledge
    @(negedge clk);
    addrIn = 12'h020; ctiIn = 3'b010; bteIn = 2'b00; we = 1'b0; stb = 1'b1; cyc = 1'b1;
    @(negedge clk);
    check(pAck == 1'b1 && pDat == 32'h12345678, "R9", pDat, 32'h12345678);
    @(negedge clk);
    check(pAck == 1'b0, "R9", {31'b0, pAck}, 32'd0);
    @(negedge clk);
    check(pAck == 1'b1, "R9", {31'b0, pAck}, 32'd1);
    @(negedge clk);
    check(pAck == 1'b0, "R9", {31'b0, pAck}, 32'd0);
    stb = 1'b0; cyc = 1'b0; ctiIn = 3'b000;
    check(pErr == 1'b0 && pRty == 1'b0, "R8", {30'b0, pErr, pRty}, 32'd0);
    useP = 1'b0;

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule